// File: doc/BRIEF.md
# Reloading PWM Timer with Event Counter

This block is an 8-bit up-counter that, after reaching its top count of FFh, restarts from a software-chosen reload value rather than from zero. The reload value therefore sets both the PWM period and, in event-counting use, how many events pass before the timer flags. Every pass through the top count sets a sticky overflow flag. The flag can raise an interrupt request, and it stays set until software clears it.

The counter advances on one of two count sources. The first is a prescaled enable pulse from elsewhere on the chip. The second is an asynchronous external event pin. The event pin is brought into the clock domain through two flip-flops, and each rising edge on it counts exactly once. Each PWM channel compares the counter against its own duty value and has its own output enable and polarity. A duty value written while the timer runs is held back until the next reload, so no period is ever cut short.

Software programs the block through a plain write port. There are no stream interfaces, so no valid/ready handshake is involved. A write takes effect at the clock edge on which `wr_en` is sampled high.

Top module: `art_pwm_timer`

## Requirements
- R1: After reset the counter, flag, interrupt and all PWM outputs are 0. The counter advances by exactly one per selected count pulse while the run bit (control register at address 0, bit 0) is 1. While the run bit is 0, the counter holds its value whatever the count source does.
- R2: A count pulse taken while the counter is at FFh loads the reload register (address 1) into the counter instead of wrapping to 00h.
- R3: Each such reload sets the overflow flag. The flag stays set until a write to address 0 with bit 3 set. If an overflow happens in the same cycle as that write, the flag stays set.
- R4: The interrupt output is high exactly when the overflow flag is set and the interrupt enable (address 0, bit 1) is 1.
- R5: With the source bit (address 0, bit 2) at 1, each rising edge on `ext_evt` advances the counter once, 3 clock edges after it is sampled, and `int_tick` is ignored. Starting from reload value V, the flag sets on the (256 − V)-th event.
- R6: With the source bit at 0, the counter advances on `int_tick` and ignores `ext_evt`.
- R7: With polarity 0, channel i drives 1 while the counter is greater than or equal to its active duty value, and 0 otherwise. A duty value equal to the reload value gives an output that is always high; FFh gives an output high for one count per period.
- R8: Bit i of the polarity register (address 3) inverts channel i.
- R9: With bit i of the output-enable register (address 2) at 0, channel i drives 0.
- R10: Duty register i sits at address 4+i. While running, a write to it becomes active at the next reload. While stopped, the written value becomes active within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| int_tick | input | 1 | Prescaled internal count enable |
| ext_evt | input | 1 | Asynchronous external event pin |
| count_o | output | 8 | Current counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |
| pwm_o | output | NCH | PWM outputs, one per channel |

## Verification
The counter, flag and active duty value change on the edge that samples a tick or a write, and the interrupt and PWM outputs follow combinationally in the same cycle. An external event appears in the count on the third edge after the pin is sampled high. The bench drives stimulus on falling edges and waits out these latencies inside each task before it checks. Every check is made on a falling edge against a bench-side model of counter, flag and active duty, which is updated only from the stimulus the bench applied.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int ADR_W = 3;
  localparam logic [ADR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADR_W-1:0] A_OE     = 3'd2;
  localparam logic [ADR_W-1:0] A_POL    = 3'd3;
  localparam logic [ADR_W-1:0] A_DUTY0  = 3'd4;
  localparam int B_RUN = 0;
  localparam int B_IE  = 1;
  localparam int B_EXT = 2;
  localparam int B_CLR = 3;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
endpackage

// File: rtl/art_regs.sv
module art_regs
  import art_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADR_W-1:0]         wr_addr,
  input  logic [CW-1:0]            wr_data,
  output logic                     run,
  output logic                     ie,
  output src_e                     src,
  output logic                     ovf_clr,
  output logic [CW-1:0]            reload,
  output logic [NCH-1:0]           oe,
  output logic [NCH-1:0]           pol,
  output logic [NCH-1:0][CW-1:0]   duty
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign ovf_clr = wr_ctrl && wr_data[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ie     <= 1'b0;
      src    <= SRC_INT;
      reload <= '0;
      oe     <= '0;
      pol    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run <= wr_data[B_RUN];
          ie  <= wr_data[B_IE];
          src <= wr_data[B_EXT] ? SRC_EXT : SRC_INT;
        end
        A_RELOAD: reload <= wr_data;
        A_OE:     oe     <= wr_data[NCH-1:0];
        A_POL:    pol    <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_duty
    localparam logic [ADR_W-1:0] ADR_I = A_DUTY0 + ADR_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        duty[i] <= '0;
      else if (wr_en && (wr_addr == ADR_I))
        duty[i] <= wr_data;
    end
  end
endmodule

// File: rtl/art_evt_sync.sv
module art_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic evt_pulse
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], evt_async};
  end

  assign evt_pulse = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];
endmodule

// File: rtl/art_counter.sv
module art_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] reload,
  input  logic          ovf_clr,
  output logic [CW-1:0] count,
  output logic          ovf_evt,
  output logic          flag
);
  localparam logic [CW-1:0] TOP = '1;

  assign ovf_evt = step && (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (ovf_evt) count <= reload;
    else if (step)    count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (ovf_evt) flag <= 1'b1;
    else if (ovf_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/art_pwm_chan.sv
module art_pwm_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] duty_wr,
  input  logic          reload_evt,
  input  logic          run,
  input  logic          oe,
  input  logic          pol,
  output logic          pwm
);
  logic [CW-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  duty_act <= '0;
    else if (!run || reload_evt) duty_act <= duty_wr;
  end

  assign pwm = oe & ((count >= duty_act) ^ pol);
endmodule

// File: rtl/art_pwm_timer.sv
module art_pwm_timer
  import art_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NCH   = 2   // at most 4 with the 3-bit address map
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             int_tick,
  input  logic             ext_evt,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             irq_o,
  output logic [NCH-1:0]   pwm_o
);
  logic                        run_q, ie_q, ovf_clr, evt_pulse, step, ovf_evt;
  src_e                        src_q;
  logic [CNT_W-1:0]            reload_q;
  logic [NCH-1:0]              oe_q, pol_q;
  logic [NCH-1:0][CNT_W-1:0]   duty_q;

  art_regs #(.CW(CNT_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run_q), .ie(ie_q), .src(src_q),
    .ovf_clr(ovf_clr), .reload(reload_q), .oe(oe_q), .pol(pol_q),
    .duty(duty_q)
  );

  art_evt_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_async(ext_evt), .evt_pulse(evt_pulse)
  );

  assign step = run_q && ((src_q == SRC_EXT) ? evt_pulse : int_tick);

  art_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .reload(reload_q),
    .ovf_clr(ovf_clr), .count(count_o), .ovf_evt(ovf_evt),
    .flag(ovf_flag_o)
  );

  assign irq_o = ovf_flag_o & ie_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    art_pwm_chan #(.CW(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .count(count_o), .duty_wr(duty_q[i]),
      .reload_evt(ovf_evt), .run(run_q), .oe(oe_q[i]), .pol(pol_q[i]),
      .pwm(pwm_o[i])
    );
  end
endmodule

// File: rtl/art_pwm_timer_chk.sv
module art_pwm_timer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          step,
  input logic          clr_req,
  input logic [CW-1:0] count,
  input logic [CW-1:0] reload,
  input logic          flag
);
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
  // R1
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count != '1) |=> count == CW'($past(count) + 1'b1));
  // R2
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == '1) |=> count == $past(reload));
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == '1) |=> flag);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

bind art_pwm_timer art_pwm_timer_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .step(step), .clr_req(ovf_clr),
  .count(count_o), .reload(reload_q), .flag(ovf_flag_o)
);

// File: tb/sim_art_pwm_timer.sv
module sim_art_pwm_timer;
  localparam int NCH = 2;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, int_tick = 1'b0, ext_evt = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count_o;
  logic ovf_flag_o, irq_o;
  logic [NCH-1:0] pwm_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_cnt = 0, rl_m = 0;
  logic exp_flag = 0, run_m = 0, ie_m = 0, ext_m = 0;
  logic [7:0] duty_m [NCH];
  logic [7:0] act_m [NCH];
  logic [NCH-1:0] oe_m = 0, pol_m = 0;

  always #10 clk = ~clk;

  art_pwm_timer #(.CNT_W(8), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .int_tick(int_tick), .ext_evt(ext_evt),
    .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o), .pwm_o(pwm_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mstep();
    if (exp_cnt == 8'hFF) begin
      exp_cnt = rl_m;
      exp_flag = 1'b1;
      for (int i = 0; i < NCH; i++) act_m[i] = duty_m[i];
    end else exp_cnt = exp_cnt + 8'd1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    case (a)
      3'd0: begin
        run_m = d[0]; ie_m = d[1]; ext_m = d[2];
        if (d[3]) exp_flag = 1'b0;
        if (!run_m) for (int i = 0; i < NCH; i++) act_m[i] = duty_m[i];
      end
      3'd1: rl_m = d;
      3'd2: oe_m = d[NCH-1:0];
      3'd3: pol_m = d[NCH-1:0];
      default: begin
        duty_m[a-3'd4] = d;
        if (!run_m) act_m[a-3'd4] = d;
      end
    endcase
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      int_tick = 1'b1;
      repeat (n) @(negedge clk);
      int_tick = 1'b0;
      if (run_m && !ext_m) for (int k = 0; k < n; k++) mstep();
    end
  endtask

  task automatic evt();
    ext_evt = 1'b1;
    repeat (2) @(negedge clk);
    ext_evt = 1'b0;
    repeat (4) @(negedge clk);
    if (run_m && ext_m) mstep();
  endtask

  task automatic chk_state(input string tag);
    check({tag, " count"}, count_o, exp_cnt);
    check({tag, " flag"}, ovf_flag_o, exp_flag);
    check({tag, " irq R4"}, irq_o, exp_flag & ie_m);
  endtask

  task automatic chk_pwm(input string tag);
    for (int i = 0; i < NCH; i++)
      check($sformatf("%s pwm%0d", tag, i), pwm_o[i],
            oe_m[i] ? ((exp_cnt >= act_m[i]) ^ pol_m[i]) : 1'b0);
  endtask

  task automatic t_reset();
    chk_state("R1 reset");
    check("R1 reset pwm", pwm_o, 0);
  endtask

  task automatic t_count();
    ticks(5);
    chk_state("R1 hold while stopped");
    wr(3'd1, 8'hF0);
    wr(3'd0, 8'h01);
    ticks(10);
    chk_state("R1 increment");
    check("R1 literal count", count_o, 8'h0A);
    ticks(245);
    chk_state("R1 at top");
    ticks(1);
    chk_state("R2 reload not zero");
    check("R2 literal reload", count_o, 8'hF0);
    check("R3 flag set", ovf_flag_o, 1);
    check("R4 irq masked", irq_o, 0);
    wr(3'd0, 8'h03);
    check("R4 irq enabled", irq_o, 1);
    ticks(20);
    chk_state("R3 flag sticky over second overflow");
    evt();
    chk_state("R6 ext_evt ignored in internal mode");
    wr(3'd0, 8'h0B);
    chk_state("R3 flag cleared");
  endtask

  task automatic t_ext();
    wr(3'd1, 8'hFD);
    while (exp_cnt != rl_m) ticks(1);
    chk_state("R2 reached new reload");
    wr(3'd0, 8'h0D);
    ticks(3);
    chk_state("R5 int_tick ignored in external mode");
    evt();
    evt();
    chk_state("R5 two events");
    check("R5 no flag before 256-V events", ovf_flag_o, 0);
    evt();
    chk_state("R5 third event");
    check("R5 flag after 256-V events", ovf_flag_o, 1);
    wr(3'd0, 8'h04);
    evt();
    evt();
    chk_state("R1 events held when stopped");
  endtask

  task automatic t_pwm();
    wr(3'd1, 8'hFC);
    wr(3'd0, 8'h09);
    while (exp_cnt != rl_m) ticks(1);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h02);
    wr(3'd4, 8'hFE);
    wr(3'd5, 8'hFE);
    wr(3'd0, 8'h01);
    for (int k = 0; k < 5; k++) begin
      chk_pwm("R7 R8 mid duty");
      ticks(1);
    end
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hFC);
    wr(3'd5, 8'hFF);
    chk_pwm("R10 immediate when stopped");
    wr(3'd0, 8'h01);
    for (int k = 0; k < 5; k++) begin
      chk_pwm("R7 extremes");
      ticks(1);
    end
    wr(3'd4, 8'hFF);
    check("R10 buffered duty not yet active", pwm_o[0], 1);
    chk_pwm("R10 buffered");
    while (exp_cnt != rl_m) ticks(1);
    chk_pwm("R10 active after reload");
    check("R10 literal after reload", pwm_o[0], 0);
    wr(3'd2, 8'h01);
    for (int k = 0; k < 4; k++) begin
      chk_pwm("R9 output disabled");
      ticks(1);
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin duty_m[i] = 0; act_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_ext();
    t_pwm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule